// File: doc/BRIEF.md
# Edge-Triggered Counter Capture Unit

This block records the instant at which an external signal changes. A free-running 16-bit count value enters from a neighbouring timer; when the chosen transition appears on the asynchronous capture pin, that count is stored in a capture register and a sticky capture flag is raised for software or an interrupt controller to observe.

The pin is first brought into the clock domain by a two-flop synchronizer. An optional glitch filter can then be switched in. With the filter on, the level used for edge detection changes only after four consecutive synchronized samples agree on the new value. Either the rising or the falling transition can be chosen as the trigger.

When the timer is running in a mode that uses the capture register as its period limit, capture events still raise the flag but leave the stored value alone. A later capture simply overwrites an earlier one that has not been read.

Top module: `icap_unit`

## Requirements
- R1: On a capture event, the value present on `count_i` in the cycle of the event is stored in `cap_val_o`. The stored value is visible after the clock edge that ends that cycle.
- R2: With `edge_rise_i` = 1, a low-to-high transition of the synchronized (or filtered) pin level is a capture event.
- R3: With `edge_rise_i` = 0, a high-to-low transition is a capture event. The opposite transition leaves the flag and the register unchanged.
- R4: With the filter off, a pin change set up before rising clock edge k becomes visible on the outputs after edge k+2, and not before.
- R5: With `filt_en_i` = 1, the filtered level follows the pin only after four consecutive samples agree. A pin pulse of three clocks or fewer produces no capture. A pulse of four clocks or more is captured. Latency grows by four clocks, so the capture appears after edge k+6.
- R6: Every capture event sets `cap_flag_o` to 1. The flag remains set until it is cleared.
- R7: `flag_clr_i` = 1 clears `cap_flag_o` at the next edge. If a capture event occurs in the same cycle, the flag is set instead.
- R8: While `cap_is_top_i` = 1, capture events do not change `cap_val_o`, but they still set the flag.
- R9: A second capture with the flag still set overwrites `cap_val_o` with the newer count.
- R10: After reset, `cap_val_o` = 0 and `cap_flag_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cap_pin_i | input | 1 | Raw asynchronous capture pin |
| count_i | input | 16 | Running timer count |
| edge_rise_i | input | 1 | 1: trigger on rising edge, 0: trigger on falling edge |
| filt_en_i | input | 1 | Enables the four-sample glitch filter |
| flag_clr_i | input | 1 | Clears the capture flag |
| cap_is_top_i | input | 1 | Capture register is in use as the period limit; blocks overwrites |
| cap_val_o | output | 16 | Captured count |
| cap_flag_o | output | 1 | Sticky capture flag |

## Verification
The hardest case to reach from the ports is a flag clear and a capture event landing in the same cycle. The event exists only one pipeline depth after the pin moves. The bench reaches it by counting falling clock edges from the cycle the pin is driven, then raising the clear strobe for exactly the cycle before the third rising edge. Filter boundaries are reached the same way: pulses of exactly three and exactly four clocks are driven, and the glitch filter must reject the first and accept the second.

// File: rtl/icap_pkg.sv
package icap_pkg;
  parameter int unsigned ICAP_CNT_W    = 16;
  parameter int unsigned ICAP_SYNC_N   = 2;
  parameter int unsigned ICAP_FILT_LEN = 4;
endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= 1'b0;
    else         stg_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= 1'b0;
      else         stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/icap_filter.sv
module icap_filter #(
  parameter int unsigned LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned HistW = (LEN > 1) ? LEN - 1 : 1;

  logic filt_q;

  if (LEN > 1) begin : g_hist
    logic [HistW-1:0] hist_q;
    logic [LEN-1:0]   win;
    assign win = {hist_q, d_i};

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_q <= '0;
      else         hist_q <= win[HistW-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     filt_q <= 1'b0;
      else if (&win)   filt_q <= 1'b1;
      else if (~|win)  filt_q <= 1'b0;
    end
  end else begin : g_pass
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) filt_q <= 1'b0;
      else         filt_q <= d_i;
    end
  end

  assign q_o = filt_q;
endmodule

// File: rtl/icap_edge.sv
module icap_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic rise_i,
  output logic evt_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign evt_o = rise_i ? (lvl_i & ~lvl_q) : (~lvl_i & lvl_q);
endmodule

// File: rtl/icap_unit.sv
module icap_unit
  import icap_pkg::*;
#(
  parameter int unsigned CNT_W    = ICAP_CNT_W,
  parameter int unsigned SYNC_N   = ICAP_SYNC_N,
  parameter int unsigned FILT_LEN = ICAP_FILT_LEN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_pin_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             edge_rise_i,
  input  logic             filt_en_i,
  input  logic             flag_clr_i,
  input  logic             cap_is_top_i,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             cap_flag_o
);
  logic pin_sync;
  logic pin_filt;
  logic pin_lvl;
  logic cap_evt;
  logic [CNT_W-1:0] cap_q;
  logic flag_q;

  icap_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cap_pin_i),
    .q_o   (pin_sync)
  );

  // filter runs continuously so enabling it never sees stale history
  icap_filter #(.LEN(FILT_LEN)) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_sync),
    .q_o   (pin_filt)
  );

  assign pin_lvl = filt_en_i ? pin_filt : pin_sync;

  icap_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (pin_lvl),
    .rise_i(edge_rise_i),
    .evt_o (cap_evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cap_q <= '0;
    else if (cap_evt && !cap_is_top_i) cap_q <= count_i;
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (cap_evt)    flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign cap_val_o  = cap_q;
  assign cap_flag_o = flag_q;
endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] count_i,
  input logic             flag_clr_i,
  input logic             cap_is_top_i,
  input logic [CNT_W-1:0] cap_val_o,
  input logic             cap_flag_o,
  input logic             cap_evt
);
  assert_capture_value_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_evt && !cap_is_top_i) |=> (cap_val_o == $past(count_i)));

  assert_no_spurious_update_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_evt |=> $stable(cap_val_o));

  assert_flag_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt |=> cap_flag_o);

  assert_flag_rise_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cap_flag_o) |-> $past(cap_evt));

  assert_flag_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !cap_evt) |=> !cap_flag_o);

  assert_top_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_is_top_i |=> $stable(cap_val_o));
endmodule

bind icap_unit icap_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .count_i     (count_i),
  .flag_clr_i  (flag_clr_i),
  .cap_is_top_i(cap_is_top_i),
  .cap_val_o   (cap_val_o),
  .cap_flag_o  (cap_flag_o),
  .cap_evt     (cap_evt)
);

// File: tb/icap_unit_tb.sv
module icap_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  typedef struct packed {
    logic        rise;
    logic        filt;
    logic [3:0]  len;
    logic [15:0] cnt;
    logic        exp;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 4'd1, 16'h1234, 1'b1},
    '{1'b0, 1'b0, 4'd2, 16'hBEEF, 1'b1},
    '{1'b1, 1'b1, 4'd3, 16'h0F0F, 1'b0},
    '{1'b1, 1'b1, 4'd4, 16'hA5A5, 1'b1},
    '{1'b0, 1'b1, 4'd3, 16'h1111, 1'b0},
    '{1'b0, 1'b1, 4'd6, 16'h7FFE, 1'b1},
    '{1'b1, 1'b1, 4'd8, 16'hFFFF, 1'b1},
    '{1'b0, 1'b0, 4'd1, 16'h0001, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b0;
  logic [15:0] cnt = '0;
  logic        rise = 1'b1;
  logic        filt = 1'b0;
  logic        clr = 1'b0;
  logic        top = 1'b0;
  logic [15:0] val;
  logic        flag;
  int          n_run = 0;
  int          n_fail = 0;
  logic [15:0] model_val = '0;
  logic        done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  icap_unit u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cap_pin_i   (pin),
    .count_i     (cnt),
    .edge_rise_i (rise),
    .filt_en_i   (filt),
    .flag_clr_i  (clr),
    .cap_is_top_i(top),
    .cap_val_o   (val),
    .cap_flag_o  (flag)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_flag();
    clr = 1'b1;
    step(1);
    clr = 1'b0;
  endtask

  initial begin
    step(3);
    chk("R10 val after reset", val, 16'h0);
    chk("R10 flag after reset", {15'd0, flag}, 16'h0);
    rst_n = 1'b1;
    step(2);

    for (int i = 0; i < NVEC; i++) begin
      clear_flag();
      rise = VECS[i].rise;
      filt = VECS[i].filt;
      cnt  = VECS[i].cnt;
      step(1);
      pin = 1'b1;
      step(int'(VECS[i].len));
      pin = 1'b0;
      step(12);
      if (VECS[i].exp) model_val = VECS[i].cnt;
      chk($sformatf("R2 R3 R5 R6 vec%0d flag", i), {15'd0, flag}, {15'd0, VECS[i].exp});
      chk($sformatf("R1 R5 vec%0d value", i), val, model_val);
    end

    // R4: unfiltered latency, edge k+2
    filt = 1'b0; rise = 1'b1; cnt = 16'h4242;
    clear_flag();
    pin = 1'b1;
    step(2);
    chk("R4 no capture before k+2", {15'd0, flag}, 16'h0);
    step(1);
    chk("R4 capture at k+2", {15'd0, flag}, 16'h1);
    chk("R1 R4 value", val, 16'h4242);
    pin = 1'b0;
    step(6);

    // R5: filtered latency, edge k+6
    filt = 1'b1; cnt = 16'h5151;
    clear_flag();
    pin = 1'b1;
    step(6);
    chk("R5 no capture before k+6", {15'd0, flag}, 16'h0);
    step(1);
    chk("R5 capture at k+6", {15'd0, flag}, 16'h1);
    chk("R5 value", val, 16'h5151);
    pin = 1'b0;
    step(10);

    // R3: falling mode ignores rising transition
    filt = 1'b0; rise = 1'b0; cnt = 16'h6060;
    clear_flag();
    pin = 1'b1;
    step(8);
    chk("R3 rising ignored flag", {15'd0, flag}, 16'h0);
    chk("R3 rising ignored value", val, 16'h5151);
    pin = 1'b0;
    step(8);
    chk("R3 falling captured", val, 16'h6060);

    // R7: clear in the same cycle as a capture
    rise = 1'b1; cnt = 16'h7070;
    step(1);
    pin = 1'b1;
    step(2);
    clr = 1'b1;
    step(1);
    clr = 1'b0;
    chk("R7 capture wins over clear", {15'd0, flag}, 16'h1);
    clear_flag();
    chk("R7 clear takes effect", {15'd0, flag}, 16'h0);
    pin = 1'b0;
    step(6);

    // R9: overwrite without clearing
    cnt = 16'h0A0A;
    pin = 1'b1; step(6); pin = 1'b0; step(6);
    cnt = 16'h0B0B;
    pin = 1'b1; step(6); pin = 1'b0; step(6);
    chk("R9 newer value kept", val, 16'h0B0B);
    chk("R9 flag still set", {15'd0, flag}, 16'h1);

    // R8: capture register used as limit
    clear_flag();
    top = 1'b1; cnt = 16'hDEAD;
    pin = 1'b1; step(6); pin = 1'b0; step(6);
    chk("R8 value held", val, 16'h0B0B);
    chk("R8 flag still set", {15'd0, flag}, 16'h1);
    top = 1'b0;
    step(2);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule